// File: doc/BRIEF.md
# Two-Wire Register-Space Slave

This block is a serial slave on a two-wire bus (one clock line, one open-drain data line). It sits in front of a 64-byte register space. Byte positions 0 to 7 belong to an external clock/calendar block, reached through a small write/read port. Byte positions 8 to 63 are a 56-byte general-purpose RAM held inside the slave. Both bus lines are oversampled by the system clock. The slave recognises start and stop conditions, compares the device address, acknowledges, and moves data through a single 6-bit pointer. The pointer steps forward after every data byte.

In a write transfer, the first data byte after the address loads the pointer. Each later byte is stored at the pointer. A read transfer returns bytes from the current pointer, most significant bit first. It keeps going for as long as the master acknowledges. A power-fail input aborts any transfer, clears the pointer and makes the slave deaf to the bus while it stays high.

States of the byte engine:
- `ST_IDLE`: no transfer.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_WR_BYTE`: shifting in a data byte.
- `ST_WR_ACK`: acknowledging a data byte.
- `ST_RD_BYTE`: shifting out a data byte.
- `ST_RD_ACK`: sampling the master's acknowledge.
- `ST_SKIP`: not addressed or read finished, waiting for a stop.
- `ST_HALT`: power fail.

Transitions:
- Start from any state except `ST_HALT` goes to `ST_ADDR`.
- Stop goes to `ST_IDLE`.
- The eighth clock fall in `ST_ADDR` goes to `ST_ADDR_ACK` on a match and to `ST_SKIP` otherwise.
- The acknowledge fall in `ST_ADDR_ACK` goes to `ST_RD_BYTE` or `ST_WR_BYTE`, chosen by the R/W bit.
- The eighth fall in `ST_WR_BYTE` goes to `ST_WR_ACK`, and the next fall returns to `ST_WR_BYTE`.
- The eighth fall in `ST_RD_BYTE` goes to `ST_RD_ACK`. From there the next fall goes to `ST_RD_BYTE` on a master ACK and to `ST_SKIP` on a NACK.
- Power fail goes to `ST_HALT` from anywhere. Its release goes to `ST_IDLE`.

Top module: `twr_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal 1101000; bit 0 is R/W (0 = write, 1 = read). After any other address it leaves SDA released for every later byte and changes nothing until the next start.
- R2: Pointer values 0 to 7 reach the calendar port, with `cal_addr` equal to the pointer's low three bits and `cal_we` pulsing once per written byte. Values 8 to 63 read and write the internal RAM.
- R3: In a write transfer, the first data byte loads its low six bits into the pointer. Every later byte is stored at the pointer, which then advances by one. Every data byte of a matched write is acknowledged by pulling SDA low during the ninth clock.
- R4: A read transfer returns the byte at the current pointer, MSB first, and advances the pointer after each byte. It continues while the master acknowledges. A master NACK ends it, and SDA stays released until the next start.
- R5: The pointer wraps from 63 to 0 in both reads and writes.
- R6: SDA falling while SCL is high is a start, and it restarts address reception even in the middle of a transfer. SDA rising while SCL is high is a stop, and it returns the slave to idle.
- R7: While `pwr_fail` is high, the transfer is abandoned, SDA is released, the pointer is 0 and bus activity changes nothing. After release, reads begin at position 0.
- R8: `sda_oe` is high only to acknowledge or to send a 0 data bit. Otherwise the data line is released.
- R9: After reset the slave is idle with SDA released and the pointer at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_fail | input | 1 | High while the supply is out of tolerance |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| cal_addr | output | 3 | Calendar byte selected by the pointer |
| cal_wdata | output | 8 | Byte to store in the calendar |
| cal_we | output | 1 | Calendar write strobe |
| cal_rdata | input | 8 | Calendar byte at `cal_addr` |

## Verification
The register space is filled by one 65-byte write burst from position 0. A single read burst then returns all 64 positions plus one, which separates correct calendar/RAM routing and pointer wrap from off-by-one pointer steps. The read runs through a repeated start, which shows whether a start in mid-transfer resets address reception. Every write address from 0 to 127 is swept, so only 1101000 may draw an ACK, and a mismatched address followed by data must leave the stored bytes untouched. A power fail raised in the middle of a byte, with a full write sent while it is held, tells pointer clearing apart from writes that should have been ignored.

// File: rtl/twr_pkg.sv
package twr_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_SKIP,
        ST_HALT
    } twr_state_t;
endpackage

// File: rtl/twr_line_sync.sv
module twr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_cond,
    output logic stop_cond
);
    // [STAGES-1] is the synchronized level, [STAGES] the previous one
    logic [STAGES:0] scl_p;
    logic [STAGES:0] sda_p;
    logic scl_s, scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[STAGES-1:0], scl_in};
            sda_p <= {sda_p[STAGES-1:0], sda_in};
        end
    end

    assign scl_s      = scl_p[STAGES-1];
    assign scl_q      = scl_p[STAGES];
    assign sda_s      = sda_p[STAGES-1];
    assign sda_q      = sda_p[STAGES];
    assign scl_rise   = scl_s & ~scl_q;
    assign scl_fall   = ~scl_s & scl_q;
    assign start_cond = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_cond  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twr_regspace.sv
module twr_regspace #(
    parameter int SPACE_BYTES = 64,
    parameter int CAL_BYTES   = 8,
    localparam int AW = $clog2(SPACE_BYTES),
    localparam int CW = $clog2(CAL_BYTES)
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic          we,
    output logic [7:0]    rdata,
    output logic [CW-1:0] cal_addr,
    output logic [7:0]    cal_wdata,
    output logic          cal_we,
    input  logic [7:0]    cal_rdata
);
    localparam int RAM_N = SPACE_BYTES - CAL_BYTES;

    logic [7:0]    ram [RAM_N];
    logic          in_cal;
    logic [AW-1:0] ram_idx;

    assign in_cal  = addr < AW'(CAL_BYTES);
    assign ram_idx = in_cal ? '0 : addr - AW'(CAL_BYTES);

    always_ff @(posedge clk) begin
        if (we && !in_cal) ram[ram_idx] <= wdata;
    end

    assign rdata     = in_cal ? cal_rdata : ram[ram_idx];
    assign cal_addr  = addr[CW-1:0];
    assign cal_wdata = wdata;
    assign cal_we    = we && in_cal;
endmodule

// File: rtl/twr_slave.sv
module twr_slave
    import twr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1101000,
    parameter int         SPACE_BYTES = 64,
    parameter int         CAL_BYTES   = 8,
    parameter int         SYNC_STAGES = 2,
    localparam int PW = $clog2(SPACE_BYTES),
    localparam int CW = $clog2(CAL_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_fail,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_oe,
    output logic [CW-1:0] cal_addr,
    output logic [7:0]    cal_wdata,
    output logic          cal_we,
    input  logic [7:0]    cal_rdata
);
    twr_state_t    state, state_nx;
    logic          sda_s, scl_rise, scl_fall, start_cond, stop_cond;
    logic [7:0]    shreg, txbyte, rd_byte;
    logic [3:0]    bitcnt;
    logic [PW-1:0] ptr;
    logic          rw, ptr_load, mack, wr_en, byte_in_done;

    twr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_cond(start_cond), .stop_cond(stop_cond)
    );

    twr_regspace #(.SPACE_BYTES(SPACE_BYTES), .CAL_BYTES(CAL_BYTES)) u_space (
        .clk(clk), .addr(ptr), .wdata(shreg), .we(wr_en), .rdata(rd_byte),
        .cal_addr(cal_addr), .cal_wdata(cal_wdata), .cal_we(cal_we),
        .cal_rdata(cal_rdata)
    );

    assign byte_in_done = scl_fall && (bitcnt == 4'd8);

    // next-state logic
    always_comb begin
        state_nx = state;
        if (pwr_fail)                state_nx = ST_HALT;
        else if (state == ST_HALT)   state_nx = ST_IDLE;
        else if (start_cond)         state_nx = ST_ADDR;
        else if (stop_cond)          state_nx = ST_IDLE;
        else begin
            unique case (state)
                ST_ADDR:     if (byte_in_done)
                                 state_nx = (shreg[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall) state_nx = rw ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_in_done) state_nx = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_nx = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && bitcnt == 4'd7) state_nx = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_nx = mack ? ST_RD_BYTE : ST_SKIP;
                ST_IDLE, ST_SKIP, ST_HALT: state_nx = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0; txbyte <= '0; bitcnt <= '0; ptr <= '0;
            rw <= 1'b0; ptr_load <= 1'b0; mack <= 1'b0;
        end else if (pwr_fail) begin
            ptr    <= '0;
            bitcnt <= '0;
        end else if (start_cond) begin
            bitcnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (byte_in_done) begin
                        if (state == ST_ADDR) begin
                            rw       <= shreg[0];
                            ptr_load <= 1'b1;
                        end else begin
                            ptr      <= ptr_load ? shreg[PW-1:0] : ptr + 1'b1;
                            ptr_load <= 1'b0;
                        end
                    end
                end
                ST_ADDR_ACK, ST_WR_ACK: if (scl_fall) begin
                    bitcnt <= '0;
                    txbyte <= rd_byte;
                end
                ST_RD_BYTE: if (scl_fall) begin
                    txbyte <= {txbyte[6:0], 1'b0};
                    bitcnt <= bitcnt + 4'd1;
                    if (bitcnt == 4'd7) ptr <= ptr + 1'b1;
                end
                ST_RD_ACK: begin
                    if (scl_rise) mack <= ~sda_s;
                    if (scl_fall) begin
                        txbyte <= rd_byte;
                        bitcnt <= '0;
                    end
                end
                ST_IDLE, ST_SKIP, ST_HALT: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        wr_en  = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~txbyte[7];
            ST_WR_BYTE:             wr_en  = byte_in_done && !ptr_load && !pwr_fail;
            ST_IDLE, ST_ADDR, ST_RD_ACK, ST_SKIP, ST_HALT: ;
        endcase
    end

    assert_pf_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_fail) |-> (ptr == '0 && !sda_oe));

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |-> ($past(pwr_fail) || $past(ptr_load) ||
                                 ptr == PW'($past(ptr) + 1'b1)));

    assert_quiet_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_SKIP || state == ST_HALT) |-> !sda_oe);

    assert_stop_idles_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_cond && state != ST_HALT) |=> (state == ST_IDLE || state == ST_HALT));

    assert_nack_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK && scl_fall && !mack && !pwr_fail && !start_cond && !stop_cond)
            |=> (state == ST_SKIP || state == ST_HALT));

    assert_skip_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !cal_we);
endmodule

// File: tb/twr_slave_tb.sv
module twr_slave_tb;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_fail = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe, cal_we, sda_bus;
    logic [2:0] cal_addr;
    logic [7:0] cal_wdata, cal_rdata;
    logic [7:0] cal_m [8];
    logic [7:0] exp_mem [64];
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_oe ? 1'b0 : sda_m;

    twr_slave u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .scl_in(scl),
        .sda_in(sda_bus), .sda_oe(sda_oe), .cal_addr(cal_addr),
        .cal_wdata(cal_wdata), .cal_we(cal_we), .cal_rdata(cal_rdata)
    );

    always @(posedge clk) if (cal_we) cal_m[cal_addr] <= cal_wdata;
    assign cal_rdata = cal_m[cal_addr];

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic check(input string req, input int act, input int expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = sda_bus; wq(); scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic b;
        for (int k = 7; k >= 0; k--) send_bit(d[k]);
        recv_bit(b);
        acked = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int k = 7; k >= 0; k--) begin
            recv_bit(b);
            d[k] = b;
        end
        send_bit(~give_ack);
    endtask

    initial begin
        for (int c = 0; c < 190000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic       a;
        logic [7:0] d;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 sda released after reset", sda_oe, 0);

        // 65-byte write burst from position 0, last byte wraps to 0
        bus_start();
        send_byte(8'hD0, a); check("R1 write address ack", a, 1);
        send_byte(8'h00, a); check("R3 pointer byte ack", a, 1);
        for (int i = 0; i < 65; i++) begin
            send_byte(pat(i), a);
            check(i == 64 ? "R5 write wrap ack" : "R3 data ack", a, 1);
            exp_mem[i % 64] = pat(i);
        end
        bus_stop();
        for (int j = 0; j < 8; j++) check("R2 calendar port contents", cal_m[j], exp_mem[j]);

        // pointer set, repeated start, 65-byte read
        bus_start();
        send_byte(8'hD0, a); check("R1 write address ack", a, 1);
        send_byte(8'h00, a); check("R3 pointer byte ack", a, 1);
        bus_start();
        send_byte(8'hD1, a); check("R6 repeated start read address ack", a, 1);
        for (int i = 0; i < 65; i++) begin
            recv_byte(d, i != 64);
            check(i == 64 ? "R5 read wrap" : (i < 8 ? "R2 calendar read" : "R4 RAM read"),
                  d, exp_mem[i % 64]);
        end
        check("R8 released after NACK", sda_oe, 0);
        bus_stop();
        check("R6 released after stop", sda_oe, 0);

        // mismatched address followed by data
        bus_start();
        send_byte(8'hA0, a); check("R1 foreign address nack", a, 0);
        send_byte(8'h05, a); check("R1 foreign data nack", a, 0);
        send_byte(8'h77, a); check("R1 foreign data nack", a, 0);
        bus_stop();
        check("R1 calendar untouched", cal_m[5], exp_mem[5]);
        bus_start();
        send_byte(8'hD1, a); check("R1 read address ack", a, 1);
        recv_byte(d, 1'b0); check("R4 read at current pointer", d, exp_mem[1]);
        bus_stop();

        // sweep all write addresses
        for (int ad = 0; ad < 128; ad++) begin
            bus_start();
            send_byte({7'(ad), 1'b0}, a);
            check("R1 address sweep", a, (ad == 7'h68) ? 1 : 0);
            bus_stop();
        end

        // power fail in mid-byte, then a full write while held
        bus_start();
        send_byte(8'hD0, a); check("R3 address ack", a, 1);
        send_byte(8'h20, a); check("R3 pointer ack", a, 1);
        send_byte(8'hAB, a); check("R3 data ack", a, 1);
        exp_mem[32] = 8'hAB;
        for (int k = 0; k < 4; k++) send_bit(1'b0);
        pwr_fail = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 released on power fail", sda_oe, 0);
        bus_stop();
        bus_start();
        send_byte(8'hD0, a); check("R7 ignored address", a, 0);
        send_byte(8'h30, a); check("R7 ignored pointer", a, 0);
        send_byte(8'h11, a); check("R7 ignored data", a, 0);
        bus_stop();
        pwr_fail = 1'b0;
        repeat (10) @(negedge clk);
        bus_start();
        send_byte(8'hD1, a); check("R7 read address ack", a, 1);
        recv_byte(d, 1'b1); check("R7 pointer cleared", d, exp_mem[0]);
        recv_byte(d, 1'b0); check("R7 pointer steps after clear", d, exp_mem[1]);
        bus_stop();
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h30, a);
        bus_start();
        send_byte(8'hD1, a);
        recv_byte(d, 1'b1); check("R7 RAM untouched", d, exp_mem[48]);
        recv_byte(d, 1'b0); check("R4 next byte", d, exp_mem[49]);
        bus_stop();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule